// File: doc/BRIEF.md
# Tiny Accumulator Processor Core

This block is a minimal 8-bit processor built around a single accumulator. Every instruction is one byte. The upper five bits select the operation and the lower three bits carry either a register number or a small immediate. The core has eight general registers, a carry flag, a 256-entry instruction ROM and a 256-byte data RAM.

The core executes one instruction per clock. The ROM image is a parameter of the top module, so each instance runs a fixed program. Stores write the contents of a register to the RAM location addressed by the accumulator. The store strobe, address and data are visible on the ports. A side read port lets the surrounding logic inspect any RAM byte without disturbing execution.

A jump takes two instructions. The first one latches a 3-bit low field. The second one supplies the 3-bit high field, and the two fields form a 6-bit target. The jump is taken when the accumulator is zero or the carry flag is set. With a zero accumulator the jump is unconditional, and with a non-zero accumulator it branches on carry.

Top module: `acc8_core`

## Requirements
- R1: When `rst_n` is low at a clock edge, the next state has the PC, accumulator, carry flag, all eight registers and the latched jump field at zero.
- R2: Every instruction completes in one clock. Unless a jump is taken, the PC advances by one, and it wraps from 0xFF to 0x00.
- R3: Opcode bits [7:3] = 00001 (bytes 0x08 to 0x0F) load the zero-extended 3-bit immediate in bits [2:0] into the accumulator. The carry flag is not changed.
- R4: Opcode 01001 (0x48 | r) copies the accumulator into register r. Opcode 01010 (0x50 | r) copies register r into the accumulator. Here r is bits [2:0].
- R5: Opcode 00011 (0x18 | r) writes register r into the data RAM at the address held in the accumulator. During that instruction's cycle it drives `mem_we_o` high with the address and data on `mem_addr_o` and `mem_wdata_o`.
- R6: Opcode 01111 (0x78 | r) replaces the accumulator with the low 8 bits of accumulator plus register r, and sets the carry flag to the 9th bit of that sum.
- R7: Opcode 10001 (0x88 | k) adds the zero-extended immediate k to the accumulator modulo 256. The carry flag is left unchanged.
- R8: Opcode 11100 (0xE0 | k) latches k as the low jump field. Opcode 11111 (0xF8 | k) forms the target {00, k, latched field}, with k in target bits [5:3].
- R9: An 11111 instruction loads the target into the PC when the accumulator is zero or the carry flag is one. Otherwise it falls through to PC + 1.
- R10: Any other opcode changes nothing but the PC, which advances by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_o | output | 8 | Address of the instruction now executing |
| acc_o | output | 8 | Accumulator |
| carry_o | output | 1 | Carry flag |
| mem_we_o | output | 1 | High during a store instruction |
| mem_addr_o | output | 8 | RAM address of the store (the accumulator) |
| mem_wdata_o | output | 8 | Register value being stored |
| peek_addr_i | input | 8 | Address for the side read of the data RAM |
| peek_data_o | output | 8 | Data RAM byte at `peek_addr_i`, combinational |

## Verification
The hardest situation to reach is a conditional jump with a non-zero accumulator. That case depends on the carry flag left behind by an earlier addition, and a later immediate load or increment must not disturb it. The directed program builds a carry out of a chain of register doublings that reaches 256. It then reloads and increments the accumulator, so the taken branch relies on a carry that survived those operations. A later addition without overflow sets up the not-taken case. PC wrap is equally awkward, because jump targets cannot exceed 0x3F. The program therefore jumps to 0x3F and lets the empty ROM run out to 0xFF. A second instance runs a Fibonacci program whose overflowing addition ends in a self-jump, and its RAM is read back through the side port.

// File: rtl/acc8_pkg.sv
// Shared encodings for the accumulator core.
// Assumes an instruction is OPC_W opcode bits above ARG_W operand bits.
package acc8_pkg;

    localparam int OPC_W = 5;
    localparam int ARG_W = 3;
    localparam int INSTR_W = OPC_W + ARG_W;

    // Opcode field values; anything else decodes to a no-op.
    typedef enum logic [OPC_W-1:0] {
        OP_LDI   = 5'b00001,
        OP_STORE = 5'b00011,
        OP_TOREG = 5'b01001,
        OP_FROMR = 5'b01010,
        OP_ADDR  = 5'b01111,
        OP_ADDI  = 5'b10001,
        OP_JLO   = 5'b11100,
        OP_JHI   = 5'b11111
    } op_e;

    // Source of the next accumulator value.
    typedef enum logic [2:0] {
        ACC_HOLD,
        ACC_IMM,
        ACC_REG,
        ACC_SUM,
        ACC_INC
    } acc_sel_e;

    // Control bundle produced by the decoder.
    typedef struct packed {
        acc_sel_e acc_sel;
        logic     reg_we;
        logic     ram_we;
        logic     carry_we;
        logic     field_we;
        logic     jump_req;
    } ctl_t;

endpackage

// File: rtl/acc8_decode.sv
// Opcode decoder: turns the opcode field into datapath controls.
// Assumes: purely combinational; unlisted opcodes yield an all-idle bundle.
module acc8_decode
    import acc8_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output ctl_t             ctl_o
);

    // Map each opcode to its control bundle.
    always_comb begin
        ctl_o = '0;
        ctl_o.acc_sel = ACC_HOLD;
        case (opcode_i)
            OP_LDI:   ctl_o.acc_sel = ACC_IMM;
            OP_STORE: ctl_o.ram_we = 1'b1;
            OP_TOREG: ctl_o.reg_we = 1'b1;
            OP_FROMR: ctl_o.acc_sel = ACC_REG;
            OP_ADDR: begin
                ctl_o.acc_sel  = ACC_SUM;
                ctl_o.carry_we = 1'b1;
            end
            OP_ADDI:  ctl_o.acc_sel = ACC_INC;
            OP_JLO:   ctl_o.field_we = 1'b1;
            OP_JHI:   ctl_o.jump_req = 1'b1;
            default:  ctl_o.acc_sel = ACC_HOLD;
        endcase
    end

endmodule

// File: rtl/acc8_fetch.sv
// Program counter and instruction ROM.
// Assumes: the ROM image is a flat parameter, entry i at bits [i*INSTR_W +: INSTR_W];
// INSTR_W is a power of two; the PC wraps naturally at 2**ADDR_W.
module acc8_fetch #(
    parameter int ADDR_W  = 8,
    parameter int INSTR_W = 8,
    parameter logic [(2**ADDR_W)*INSTR_W-1:0] ROM_IMAGE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               jump_i,
    input  logic [ADDR_W-1:0]  target_i,
    output logic [ADDR_W-1:0]  pc_o,
    output logic [INSTR_W-1:0] instr_o
);

    localparam int IDX_W = ADDR_W + $clog2(INSTR_W);

    logic [ADDR_W-1:0] pc_q;
    logic [IDX_W-1:0]  base_w;

    // Advance or redirect the program counter each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (jump_i) begin
            pc_q <= target_i;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // Read the current instruction from the parameter image.
    assign base_w  = IDX_W'(pc_q) * IDX_W'(INSTR_W);
    assign instr_o = ROM_IMAGE[base_w +: INSTR_W];
    assign pc_o    = pc_q;

endmodule

// File: rtl/acc8_regfile.sv
// General register bank with one write port and one read port.
// Assumes: synchronous clear of every register; read is combinational.
module acc8_regfile #(
    parameter int NREGS  = 8,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [$clog2(NREGS)-1:0] wsel_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic [$clog2(NREGS)-1:0] rsel_i,
    output logic [DATA_W-1:0]        rdata_o
);

    localparam int SEL_W = $clog2(NREGS);

    logic [NREGS-1:0][DATA_W-1:0] bank_w;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [DATA_W-1:0] q;

        // Hold one register; load it when selected for write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we_i && (wsel_i == SEL_W'(g))) begin
                q <= wdata_i;
            end
        end

        assign bank_w[g] = q;
    end

    assign rdata_o = bank_w[rsel_i];

endmodule

// File: rtl/acc8_dram.sv
// Data RAM: one synchronous write port, one combinational read port.
// Assumes: contents are not cleared by reset.
module acc8_dram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 2**ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Commit a store at the clock edge.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/acc8_core.sv
// Single-cycle accumulator processor: fetch, decode, register bank,
// accumulator/carry/jump-field state and data RAM.
// Assumes: DATA_W equals ADDR_W (the accumulator addresses the RAM) and
// 2*ARG_W <= ADDR_W (two operand fields form a jump target).
module acc8_core
    import acc8_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [(2**ADDR_W)*INSTR_W-1:0] ROM_IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              carry_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [ADDR_W-1:0] peek_addr_i,
    output logic [DATA_W-1:0] peek_data_o
);

    localparam int NREGS = 2**ARG_W;

    logic [INSTR_W-1:0] instr_w;
    logic [OPC_W-1:0]   opcode_w;
    logic [ARG_W-1:0]   arg_w;
    logic [ADDR_W-1:0]  pc_w;
    ctl_t               ctl_w;
    logic [DATA_W-1:0]  reg_rd_w;
    logic [DATA_W:0]    sum_w;
    logic [DATA_W-1:0]  acc_d;
    logic               taken_w;
    logic [ADDR_W-1:0]  target_w;

    logic [DATA_W-1:0]  acc_q;
    logic               carry_q;
    logic [ARG_W-1:0]   field_q;

    acc8_fetch #(
        .ADDR_W    (ADDR_W),
        .INSTR_W   (INSTR_W),
        .ROM_IMAGE (ROM_IMAGE)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .jump_i   (taken_w),
        .target_i (target_w),
        .pc_o     (pc_w),
        .instr_o  (instr_w)
    );

    assign opcode_w = instr_w[INSTR_W-1 -: OPC_W];
    assign arg_w    = instr_w[ARG_W-1:0];

    acc8_decode u_decode (
        .opcode_i (opcode_w),
        .ctl_o    (ctl_w)
    );

    acc8_regfile #(
        .NREGS  (NREGS),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctl_w.reg_we),
        .wsel_i  (arg_w),
        .wdata_i (acc_q),
        .rsel_i  (arg_w),
        .rdata_o (reg_rd_w)
    );

    acc8_dram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dram (
        .clk     (clk),
        .we_i    (ctl_w.ram_we),
        .waddr_i (ADDR_W'(acc_q)),
        .wdata_i (reg_rd_w),
        .raddr_i (peek_addr_i),
        .rdata_o (peek_data_o)
    );

    // Adder shared by the register-add instruction; top bit is the carry-out.
    assign sum_w = {1'b0, acc_q} + {1'b0, reg_rd_w};

    // Pick the next accumulator value.
    always_comb begin
        case (ctl_w.acc_sel)
            ACC_IMM: acc_d = DATA_W'(arg_w);
            ACC_REG: acc_d = reg_rd_w;
            ACC_SUM: acc_d = sum_w[DATA_W-1:0];
            ACC_INC: acc_d = acc_q + DATA_W'(arg_w);
            default: acc_d = acc_q;
        endcase
    end

    // Jump decision and target assembly.
    assign taken_w  = ctl_w.jump_req && ((acc_q == '0) || carry_q);
    assign target_w = ADDR_W'({arg_w, field_q});

    // Architectural state: accumulator, carry and low jump field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
            field_q <= '0;
        end else begin
            acc_q <= acc_d;
            if (ctl_w.carry_we) begin
                carry_q <= sum_w[DATA_W];
            end
            if (ctl_w.field_we) begin
                field_q <= arg_w;
            end
        end
    end

    assign pc_o        = pc_w;
    assign acc_o       = acc_q;
    assign carry_o     = carry_q;
    assign mem_we_o    = ctl_w.ram_we;
    assign mem_addr_o  = ADDR_W'(acc_q);
    assign mem_wdata_o = reg_rd_w;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pc_w == '0 && acc_q == '0 && !carry_q && field_q == '0)); // R1

    AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_w |=> pc_w == $past(pc_w) + 1'b1); // R2

    AST_LDI_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_w == OP_LDI) |=> acc_q == DATA_W'($past(arg_w))); // R3

    AST_CARRY_ONLY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_w != OP_ADDR) |=> carry_q == $past(carry_q)); // R7

    AST_JUMP_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_w == OP_JHI && carry_q) |=>
            pc_w == ADDR_W'({$past(arg_w), $past(field_q)})); // R9

    AST_IDLE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w.acc_sel == ACC_HOLD) |=> $stable(acc_q)); // R10

endmodule

// File: tb/acc8_core_bench.sv
`timescale 1ns/1ps

// Behavioural instruction-level model of the core, used for lock-step comparison.
module acc8_core_model #(
    parameter logic [2047:0] IMG = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [7:0] pc,
    output logic [7:0] acc,
    output logic       cy,
    output logic       st_en,
    output logic [7:0] st_addr,
    output logic [7:0] st_data
);
    logic [7:0] rf [8];
    logic [2:0] jfield;
    logic [7:0] mem [256];
    logic [7:0] ins;
    int         s;

    always_comb begin
        ins     = IMG[int'(pc)*8 +: 8];
        st_en   = (ins[7:3] == 5'd3);
        st_addr = acc;
        st_data = rf[ins[2:0]];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            pc <= 8'd0; acc <= 8'd0; cy <= 1'b0; jfield <= 3'd0;
            for (int i = 0; i < 8; i++) rf[i] <= 8'd0;
        end else begin
            pc <= pc + 8'd1;
            case (ins[7:3])
                5'd1:  acc <= {5'd0, ins[2:0]};
                5'd3:  mem[acc] <= rf[ins[2:0]];
                5'd9:  rf[ins[2:0]] <= acc;
                5'd10: acc <= rf[ins[2:0]];
                5'd15: begin
                    s = int'(acc) + int'(rf[ins[2:0]]);
                    acc <= 8'(s);
                    cy  <= (s > 255);
                end
                5'd17: acc <= acc + {5'd0, ins[2:0]};
                5'd28: jfield <= ins[2:0];
                5'd31: if (acc == 8'd0 || cy) pc <= {2'b00, ins[2:0], jfield};
                default: ;
            endcase
        end
    end
endmodule

module acc8_core_bench;

    // Fibonacci program: RAM[0..] receives 1,1,2,3,... until an add overflows.
    function automatic logic [7:0] fib_byte(int i);
        case (i)
            0: return 8'h09;  1: return 8'h49;  2: return 8'h4A;  3: return 8'h08;
            4: return 8'h19;  5: return 8'h89;  6: return 8'h1A;  7: return 8'h89;
            8: return 8'h4C;  9: return 8'h51; 10: return 8'h7A; 11: return 8'h4D;
           12: return 8'h52; 13: return 8'h49; 14: return 8'h55; 15: return 8'h4A;
           16: return 8'h09; 17: return 8'hE2; 18: return 8'hFA; 19: return 8'h54;
           20: return 8'h1A; 21: return 8'h89; 22: return 8'h4C; 23: return 8'h08;
           24: return 8'hE1; 25: return 8'hF9;
            default: return 8'h00;
        endcase
    endfunction

    // Directed program: carry build-up, branch cases, no-op, run-out to wrap.
    function automatic logic [7:0] dir_byte(int i);
        case (i)
            0: return 8'h0C;  1: return 8'h48;  2: return 8'h78;  3: return 8'h48;
            4: return 8'h78;  5: return 8'h48;  6: return 8'h78;  7: return 8'h48;
            8: return 8'h78;  9: return 8'h48; 10: return 8'h78; 11: return 8'h48;
           12: return 8'h78; 13: return 8'h0B; 14: return 8'h4B; 15: return 8'h89;
           16: return 8'h30; 17: return 8'hE4; 18: return 8'hFA; 19: return 8'h0F;
           20: return 8'h1B; 21: return 8'h53; 22: return 8'h78; 23: return 8'hE6;
           24: return 8'hFB; 25: return 8'h08; 26: return 8'hE7; 27: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [2047:0] build_img(bit pick_fib);
        logic [2047:0] v;
        v = '0;
        for (int i = 0; i < 32; i++) v[i*8 +: 8] = pick_fib ? fib_byte(i) : dir_byte(i);
        return v;
    endfunction

    localparam logic [2047:0] FIB_IMG = build_img(1'b1);
    localparam logic [2047:0] DIR_IMG = build_img(1'b0);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] f_pc, f_acc, f_addr, f_wd, f_peek_a, f_peek_d;
    logic       f_cy, f_we;
    logic [7:0] d_pc, d_acc, d_addr, d_wd, d_peek_d;
    logic       d_cy, d_we;
    logic [7:0] fm_pc, fm_acc, fm_addr, fm_wd, dm_pc, dm_acc, dm_addr, dm_wd;
    logic       fm_cy, fm_we, dm_cy, dm_we;

    acc8_core #(.ROM_IMAGE(FIB_IMG)) u_acc8_core (
        .clk(clk), .rst_n(rst_n), .pc_o(f_pc), .acc_o(f_acc), .carry_o(f_cy),
        .mem_we_o(f_we), .mem_addr_o(f_addr), .mem_wdata_o(f_wd),
        .peek_addr_i(f_peek_a), .peek_data_o(f_peek_d));

    acc8_core #(.ROM_IMAGE(DIR_IMG)) u_acc8_core_dir (
        .clk(clk), .rst_n(rst_n), .pc_o(d_pc), .acc_o(d_acc), .carry_o(d_cy),
        .mem_we_o(d_we), .mem_addr_o(d_addr), .mem_wdata_o(d_wd),
        .peek_addr_i(8'd4), .peek_data_o(d_peek_d));

    acc8_core_model #(.IMG(FIB_IMG)) u_model_fib (
        .clk(clk), .rst_n(rst_n), .pc(fm_pc), .acc(fm_acc), .cy(fm_cy),
        .st_en(fm_we), .st_addr(fm_addr), .st_data(fm_wd));

    acc8_core_model #(.IMG(DIR_IMG)) u_model_dir (
        .clk(clk), .rst_n(rst_n), .pc(dm_pc), .acc(dm_acc), .cy(dm_cy),
        .st_en(dm_we), .st_addr(dm_addr), .st_data(dm_wd));

    int  n_tests = 0;
    int  n_fail = 0;
    bit  cmp_on = 1'b0;
    bit  done = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Lock-step comparison of both instances against the model, every cycle.
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R2", "fib pc", 32'(f_pc), 32'(fm_pc));
            check("R4", "fib acc", 32'(f_acc), 32'(fm_acc));
            check("R6", "fib carry", 32'(f_cy), 32'(fm_cy));
            check("R5", "fib store strobe", 32'(f_we), 32'(fm_we));
            if (fm_we) check("R5", "fib store addr/data", {16'd0, f_addr, f_wd}, {16'd0, fm_addr, fm_wd});
            check("R2", "dir pc", 32'(d_pc), 32'(dm_pc));
            check("R4", "dir acc", 32'(d_acc), 32'(dm_acc));
            check("R6", "dir carry", 32'(d_cy), 32'(dm_cy));
            check("R5", "dir store strobe", 32'(d_we), 32'(dm_we));
            if (dm_we) check("R5", "dir store addr/data", {16'd0, d_addr, d_wd}, {16'd0, dm_addr, dm_wd});
        end
    end

    initial begin
        f_peek_a = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset pc", 32'(d_pc), 32'd0);
        check("R1", "reset acc", 32'(d_acc), 32'd0);
        check("R1", "reset carry", 32'(d_cy), 32'd0);
        check("R1", "reset pc fib", 32'(f_pc), 32'd0);
        cmp_on = 1'b1;
        rst_n  = 1'b1;
        for (int n = 1; n <= 400; n++) begin
            @(negedge clk);
            case (n)
                13: begin
                    check("R6", "overflowing add acc", 32'(d_acc), 32'd0);
                    check("R6", "overflowing add carry", 32'(d_cy), 32'd1);
                end
                14: begin
                    check("R3", "immediate load acc", 32'(d_acc), 32'd3);
                    check("R3", "immediate load keeps carry", 32'(d_cy), 32'd1);
                end
                16: begin
                    check("R7", "increment acc", 32'(d_acc), 32'd4);
                    check("R7", "increment keeps carry", 32'(d_cy), 32'd1);
                end
                17: begin
                    check("R10", "no-op pc", 32'(d_pc), 32'd17);
                    check("R10", "no-op acc", 32'(d_acc), 32'd4);
                end
                19: begin
                    check("R8", "carry jump target", 32'(d_pc), 32'd20);
                    check("R5", "store strobe", 32'(d_we), 32'd1);
                    check("R5", "store address", 32'(d_addr), 32'd4);
                    check("R5", "store data", 32'(d_wd), 32'd3);
                end
                20: check("R5", "ram[4] via side port", 32'(d_peek_d), 32'd3);
                21: check("R4", "register to acc", 32'(d_acc), 32'd3);
                22: begin
                    check("R6", "add no overflow acc", 32'(d_acc), 32'd131);
                    check("R6", "add no overflow carry", 32'(d_cy), 32'd0);
                end
                24: check("R9", "not-taken jump falls through", 32'(d_pc), 32'd25);
                27: check("R8", "zero-acc jump target", 32'(d_pc), 32'd63);
                219: check("R2", "pc reaches top", 32'(d_pc), 32'd255);
                220: check("R2", "pc wraps to zero", 32'(d_pc), 32'd0);
                default: ;
            endcase
        end
        check("R9", "fib halts on carry self-jump", 32'(f_pc), 32'd18);
        check("R6", "fib final carry", 32'(f_cy), 32'd1);
        begin
            int a, b, t;
            a = 1; b = 1;
            for (int i = 0; i < 13; i++) begin
                f_peek_a = 8'(i);
                #1;
                check("R5", $sformatf("fib ram[%0d]", i), 32'(f_peek_d), 32'(a));
                t = a + b; a = b; b = t;
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule